// File: doc/BRIEF.md
# Host Port Slave Bridge

This block lets an external host with a 16-bit data bus reach a 32-bit, word-addressed memory through a set of three host-visible registers: a control word, an address pointer and a data window. Each 32-bit quantity crosses the host bus as two halfword strobes. A control bit chooses which half crosses first. The data window has two select codes. One leaves the pointer alone. The other advances the pointer by one word after each access and fetches the next word ahead of time.

On the memory side the block issues single-word read or write requests with byte strobes and holds them until the memory acknowledges. While a memory access is outstanding the host sees a wait flag and must not start a new strobe. A host address strobe can capture the select, direction and halfword inputs early, which suits hosts with multiplexed buses.

Top module: `hostPortBridge`

## Requirements
- R1: The 2-bit select decodes as 00 = control word, 01 = address pointer, 10 = data window with pointer post-increment, 11 = data window without increment.
- R2: A host strobe is active only while chip select is low and exactly one of the two data strobes is low. An access starts in the cycle the strobe becomes active. Both strobes low, or chip select high, has no effect.
- R3: The halfword flag is 0 on the first strobe of a pair and 1 on the second. With control bit 0 at 1 the low half (bits 15:0) crosses first. With it at 0 the high half (bits 31:16) crosses first.
- R4: A control write loads its bits from either halfword strobe: bit 0 is word order, bit 1 is the core interrupt request (driven on coreIntReq), and bit 2 is the host interrupt (hIntN is low while it is 1). A control read returns the same image on both halves, with bit 3 reading 1 when the block is ready.
- R5: The address pointer holds a 30-bit word address. Its low halfword is {addr[13:0],2'b00}, so bits 1:0 read 0 whatever was written. Its high halfword is addr[29:14].
- R6: A data read's first strobe launches a memory read at the pointer and raises hWait until the word arrives. The second strobe returns the other half and makes no memory request.
- R7: A data write's second strobe launches one 32-bit memory write holding both halves. hWait stays high until that write is acknowledged.
- R8: hBeN is active low: hBeN[0] low enables bits 7:0 and hBeN[1] low enables bits 15:8 of the halfword being written. These bits map onto memBe for that half and apply to data writes only.
- R9: With select 10 the pointer advances by one word after a write completes, and at the end of the second read strobe. At that end point the new word is prefetched, and a following first-half read with select 10 uses it without a new memory request.
- R10: Writing control bit 4 as 1 on the second halfword launches a memory read at the pointer. Bit 4 always reads back 0.
- R11: On a falling edge of hAsN, select, direction and halfword flag are latched and used until hAsN rises. With hAsN high they pass through directly.
- R12: After reset, all registers are cleared, hWait is 0, hIntN is 1 and coreIntReq is 0. A strobe that starts while hWait is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| hSel | input | 2 | Host register select |
| hRdWr | input | 1 | 1 = host read, 0 = host write |
| hHalf | input | 1 | Halfword flag, 0 first, 1 second |
| hDs1N | input | 1 | Data strobe one, active low |
| hDs2N | input | 1 | Data strobe two, active low |
| hCsN | input | 1 | Chip select, active low |
| hAsN | input | 1 | Address strobe, active low; tie high if unused |
| hBeN | input | 2 | Byte enables for data writes, active low |
| hWait | output | 1 | 1 = host must wait |
| hIntN | output | 1 | Host interrupt, active low |
| hData | inout | 16 | Host data bus |
| coreIntReq | output | 1 | Interrupt request toward the core |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | 30 | Memory word address |
| memBe | output | 4 | Memory byte strobes |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| memAck | input | 1 | Memory acknowledge, one cycle |

## Verification
The hardest case to reach is a strobe that arrives while a memory access is still pending. A well-behaved host never does this. The stimulus therefore releases the second write strobe early, uses a memory model with several cycles of latency, and starts an address write inside the wait window. It then reads the pointer back to show that the write was dropped. A second hard case is proving that a prefetched word is consumed without a new access. The bench counts rising edges of memReq at the memory port and compares the count before and after the host reads.

// File: rtl/hpbPkg.sv
package hpbPkg;
  // Host register select codes; the host side depends on these values.
  localparam logic [1:0] SEL_CTRL = 2'b00;
  localparam logic [1:0] SEL_ADDR = 2'b01;
  localparam logic [1:0] SEL_INC  = 2'b10;
  localparam logic [1:0] SEL_DATA = 2'b11;

  // Actions the control issues to the datapath for one cycle.
  typedef struct packed {
    logic wrCtrl;
    logic wrAddr;
    logic wrData;
    logic memRead;
    logic memWrite;
    logic incAddr;
  } hpbStrobesT;
endpackage

// File: rtl/hpbCtrl.sv
module hpbCtrl
  import hpbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hSel,
  input  logic       hRdWr,
  input  logic       hHalf,
  input  logic       hDs1N,
  input  logic       hDs2N,
  input  logic       hCsN,
  input  logic       hAsN,
  input  logic       fetchBit,
  input  logic       memAck,
  output hpbStrobesT stb,
  output logic       busy,
  output logic       drvEn,
  output logic [1:0] effSel,
  output logic       effRw,
  output logic       effHalf
);
  logic       asPrev, strobePrev, pendPre, pendInc, pendWr, rdValid;
  logic [1:0] latSel;
  logic       latRw, latHalf;
  logic       asFall, useLive, strobeAct, strobeStart, strobeEnd, isData;

  // Address strobe capture: a falling edge latches, a high level passes through
  assign asFall  = asPrev & ~hAsN;
  assign useLive = hAsN | asFall;
  assign effSel  = useLive ? hSel  : latSel;
  assign effRw   = useLive ? hRdWr : latRw;
  assign effHalf = useLive ? hHalf : latHalf;

  // Strobe is active with chip select low and exactly one data strobe low
  assign strobeAct   = ~hCsN & (hDs1N ^ hDs2N);
  assign strobeStart = strobeAct & ~strobePrev & ~busy;
  assign strobeEnd   = ~strobeAct & strobePrev;
  assign isData      = effSel[1];
  assign drvEn       = strobeAct & effRw & ~busy;

  always_comb begin
    stb = '0;
    if (strobeStart) begin
      if (!isData) begin
        if (!effRw) begin
          if (effSel == SEL_CTRL) begin
            stb.wrCtrl  = 1'b1;
            stb.memRead = effHalf & fetchBit;
          end else begin
            stb.wrAddr = 1'b1;
          end
        end
      end else if (!effRw) begin
        stb.wrData   = 1'b1;
        stb.memWrite = effHalf;
      end else if (!effHalf && !((effSel == SEL_INC) && rdValid)) begin
        stb.memRead = 1'b1;
      end
    end
    if (strobeEnd && pendPre) begin
      stb.memRead = 1'b1;
      stb.incAddr = 1'b1;
    end
    if (busy && memAck && pendInc) stb.incAddr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev     <= 1'b1;
      strobePrev <= 1'b0;
      latSel     <= '0;
      latRw      <= 1'b0;
      latHalf    <= 1'b0;
      busy       <= 1'b0;
      pendWr     <= 1'b0;
      pendInc    <= 1'b0;
      pendPre    <= 1'b0;
      rdValid    <= 1'b0;
    end else begin
      asPrev     <= hAsN;
      strobePrev <= strobeAct;
      if (asFall) begin
        latSel  <= hSel;
        latRw   <= hRdWr;
        latHalf <= hHalf;
      end
      if (stb.memRead || stb.memWrite) begin
        busy    <= 1'b1;
        pendWr  <= stb.memWrite;
        pendInc <= stb.memWrite & (effSel == SEL_INC);
      end else if (busy && memAck) begin
        busy    <= 1'b0;
        pendInc <= 1'b0;
      end
      if (strobeStart && isData && effRw && effHalf && (effSel == SEL_INC))
        pendPre <= 1'b1;
      else if (strobeEnd)
        pendPre <= 1'b0;
      if (stb.wrAddr || stb.wrData)
        rdValid <= 1'b0;
      else if (busy && memAck && !pendWr)
        rdValid <= 1'b1;
    end
  end

  // R12
  ct_busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memAck |=> busy)
    else $error("wait flag dropped without acknowledge");

  // R6
  ct_busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memAck))
    else $error("wait flag fell without a prior acknowledge");
endmodule

// File: rtl/hpbData.sv
module hpbData
  import hpbPkg::*;
#(
  parameter int HW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  hpbStrobesT          stb,
  input  logic                busy,
  input  logic [1:0]          effSel,
  input  logic                effHalf,
  input  logic [HW-1:0]       hDin,
  input  logic [HW/8-1:0]     hBeN,
  output logic [HW-1:0]       outHalf,
  output logic                hIntN,
  output logic                coreIntReq,
  output logic                memReq,
  output logic                memWe,
  output logic [2*HW-3:0]     memAddr,
  output logic [HW/4-1:0]     memBe,
  output logic [2*HW-1:0]     memWdata,
  input  logic [2*HW-1:0]     memRdata,
  input  logic                memAck
);
  localparam int WW   = 2 * HW;
  localparam int WB   = WW / 8;
  localparam int HB   = HW / 8;
  localparam int AW   = WW - 2;
  localparam int LOWA = HW - 2;

  logic          order, dspInt, hostInt;
  logic [AW-1:0] addrReg;
  logic [WW-1:0] wrWord, rdWord, nextWord;
  logic [WB-1:0] wrBe, nextBe;
  logic          halfLow;
  logic [HW-1:0] ctrlImg;

  // First strobe carries the low half when order is 1
  assign halfLow = effHalf ? ~order : order;

  always_comb begin
    nextWord = wrWord;
    nextBe   = wrBe;
    if (!effHalf) nextBe = '0;
    if (halfLow) begin
      nextWord[HW-1:0] = hDin;
      nextBe[HB-1:0]   = ~hBeN;
    end else begin
      nextWord[WW-1:HW] = hDin;
      nextBe[WB-1:HB]   = ~hBeN;
    end
  end

  always_comb begin
    ctrlImg    = '0;
    ctrlImg[0] = order;
    ctrlImg[1] = dspInt;
    ctrlImg[2] = hostInt;
    ctrlImg[3] = ~busy;
    case (effSel)
      SEL_CTRL: outHalf = ctrlImg;
      SEL_ADDR: outHalf = halfLow ? {addrReg[LOWA-1:0], 2'b00} : addrReg[AW-1:LOWA];
      default:  outHalf = halfLow ? rdWord[HW-1:0] : rdWord[WW-1:HW];
    endcase
  end

  assign hIntN      = ~hostInt;
  assign coreIntReq = dspInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      order    <= 1'b0;
      dspInt   <= 1'b0;
      hostInt  <= 1'b0;
      addrReg  <= '0;
      wrWord   <= '0;
      wrBe     <= '0;
      rdWord   <= '0;
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memBe    <= '0;
      memWdata <= '0;
    end else begin
      if (stb.wrCtrl) begin
        order   <= hDin[0];
        dspInt  <= hDin[1];
        hostInt <= hDin[2];
      end
      if (stb.wrAddr) begin
        if (halfLow) addrReg[LOWA-1:0] <= hDin[HW-1:2];
        else         addrReg[AW-1:LOWA] <= hDin;
      end
      if (stb.wrData) begin
        wrWord <= nextWord;
        wrBe   <= nextBe;
      end
      if (stb.memRead) begin
        memReq  <= 1'b1;
        memWe   <= 1'b0;
        memBe   <= '1;
        memAddr <= stb.incAddr ? addrReg + 1'b1 : addrReg;
      end else if (stb.memWrite) begin
        memReq   <= 1'b1;
        memWe    <= 1'b1;
        memBe    <= nextBe;
        memWdata <= nextWord;
        memAddr  <= addrReg;
      end else if (memReq && memAck) begin
        memReq <= 1'b0;
        if (!memWe) rdWord <= memRdata;
      end
      if (stb.incAddr) addrReg <= addrReg + 1'b1;
    end
  end

  // R7
  dp_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr))
    else $error("memory request changed before acknowledge");

  // R9
  dp_autoinc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr |=> addrReg == $past(addrReg) + 1'b1)
    else $error("pointer did not advance by one word");

  // R4
  dp_hint_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> hIntN == ~$past(hDin[2]))
    else $error("host interrupt pin does not follow control write");
endmodule

// File: rtl/hostPortBridge.sv
module hostPortBridge
  import hpbPkg::*;
#(
  parameter int HW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hSel,
  input  logic                hRdWr,
  input  logic                hHalf,
  input  logic                hDs1N,
  input  logic                hDs2N,
  input  logic                hCsN,
  input  logic                hAsN,
  input  logic [HW/8-1:0]     hBeN,
  output logic                hWait,
  output logic                hIntN,
  inout  wire  [HW-1:0]       hData,
  output logic                coreIntReq,
  output logic                memReq,
  output logic                memWe,
  output logic [2*HW-3:0]     memAddr,
  output logic [HW/4-1:0]     memBe,
  output logic [2*HW-1:0]     memWdata,
  input  logic [2*HW-1:0]     memRdata,
  input  logic                memAck
);
  hpbStrobesT    stb;
  logic          busy, drvEn, effRw, effHalf;
  logic [1:0]    effSel;
  logic [HW-1:0] outHalf;

  hpbCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hRdWr(hRdWr), .hHalf(hHalf),
    .hDs1N(hDs1N), .hDs2N(hDs2N), .hCsN(hCsN), .hAsN(hAsN),
    .fetchBit(hData[4]), .memAck(memAck), .stb(stb), .busy(busy),
    .drvEn(drvEn), .effSel(effSel), .effRw(effRw), .effHalf(effHalf)
  );

  hpbData #(.HW(HW)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .effSel(effSel),
    .effHalf(effHalf), .hDin(hData), .hBeN(hBeN), .outHalf(outHalf),
    .hIntN(hIntN), .coreIntReq(coreIntReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  assign hWait = busy;
  assign hData = drvEn ? outHalf : 'z;
endmodule

// File: tb/test_hostPortBridge.sv
`timescale 1ns/1ps
module test_hostPortBridge;
  localparam int LAT = 5;
  localparam int WD  = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hSel = 2'b00;
  logic        hRdWr = 1'b0, hHalf = 1'b0;
  logic        hDs1N = 1'b1, hDs2N = 1'b1, hCsN = 1'b1, hAsN = 1'b1;
  logic [1:0]  hBeN = 2'b00;
  logic        hWait, hIntN, coreIntReq, memReq, memWe;
  logic [29:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata, memRdata;
  logic        memAck;
  wire  [15:0] hData;
  logic        tbDrv = 1'b0;
  logic [15:0] tbOut = '0;
  assign hData = tbDrv ? tbOut : 'z;

  always #10 clk = ~clk;

  hostPortBridge i_hostPortBridge (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hRdWr(hRdWr), .hHalf(hHalf),
    .hDs1N(hDs1N), .hDs2N(hDs2N), .hCsN(hCsN), .hAsN(hAsN), .hBeN(hBeN),
    .hWait(hWait), .hIntN(hIntN), .hData(hData), .coreIntReq(coreIntReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] memInit(input int i);
    return {16'hA000 + 16'(i), 16'h5000 + 16'(i)};
  endfunction

  // Memory model with fixed latency and a request counter
  logic [31:0] mem [16];
  int          lat, reqCount;
  logic        reqPrev;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= memInit(i);
      lat <= 0; reqCount <= 0; reqPrev <= 1'b0; memAck <= 1'b0; memRdata <= '0;
    end else begin
      memAck  <= 1'b0;
      reqPrev <= memReq;
      if (memReq && !reqPrev) reqCount <= reqCount + 1;
      if (memReq && !memAck) begin
        if (lat == LAT) begin
          lat    <= 0;
          memAck <= 1'b1;
          if (memWe) begin
            for (int b = 0; b < 4; b++)
              if (memBe[b]) mem[memAddr[3:0]][8*b +: 8] <= memWdata[8*b +: 8];
          end else begin
            memRdata <= mem[memAddr[3:0]];
          end
        end else begin
          lat <= lat + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      errors++;
      $display("FAIL R12 watchdog act hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hostOp(input logic [1:0] sel, input logic rw, input logic half,
                        input logic [1:0] beN, input logic [15:0] din,
                        output logic [15:0] dout);
    @(negedge clk);
    while (hWait) @(negedge clk);
    hSel = sel; hRdWr = rw; hHalf = half; hBeN = beN; tbOut = din; tbDrv = !rw; hCsN = 1'b0;
    @(negedge clk);
    hDs1N = 1'b0;
    repeat (2) @(negedge clk);
    while (hWait) @(negedge clk);
    dout = hData;
    hDs1N = 1'b1;
    @(negedge clk);
    hCsN = 1'b1; tbDrv = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic half, input logic [15:0] din);
    logic [15:0] d;
    hostOp(sel, 1'b0, half, 2'b00, din, d);
  endtask

  task automatic rd(input logic [1:0] sel, input logic half, output logic [15:0] d);
    hostOp(sel, 1'b1, half, 2'b00, 16'h0000, d);
  endtask

  // One pulse with explicit strobe levels
  task automatic rawOp(input logic [1:0] sel, input logic [15:0] din,
                       input logic ds1N, input logic ds2N, input logic csN);
    @(negedge clk);
    hSel = sel; hRdWr = 1'b0; hHalf = 1'b1; tbOut = din; tbDrv = 1'b1; hCsN = csN;
    @(negedge clk);
    hDs1N = ds1N; hDs2N = ds2N;
    repeat (3) @(negedge clk);
    hDs1N = 1'b1; hDs2N = 1'b1;
    @(negedge clk);
    hCsN = 1'b1; tbDrv = 1'b0;
    @(negedge clk);
  endtask

  // sel, rw, half, din, expected read, requirement
  localparam logic [39:0] TBL [19] = '{
    {2'b00, 1'b0, 1'b0, 16'h0001, 16'h0000, 4'd4},  // R4 order := 1
    {2'b00, 1'b0, 1'b1, 16'h0001, 16'h0000, 4'd4},
    {2'b00, 1'b1, 1'b0, 16'h0000, 16'h0009, 4'd4},  // R4 image, ready bit
    {2'b00, 1'b1, 1'b1, 16'h0000, 16'h0009, 4'd4},
    {2'b01, 1'b0, 1'b0, 16'h0008, 16'h0000, 4'd5},  // R5 low half first
    {2'b01, 1'b0, 1'b1, 16'h0000, 16'h0000, 4'd5},
    {2'b01, 1'b1, 1'b0, 16'h0000, 16'h0008, 4'd5},
    {2'b01, 1'b1, 1'b1, 16'h0000, 16'h0000, 4'd5},
    {2'b11, 1'b0, 1'b0, 16'h5678, 16'h0000, 4'd7},  // R7 word write
    {2'b11, 1'b0, 1'b1, 16'h1234, 16'h0000, 4'd7},
    {2'b11, 1'b1, 1'b0, 16'h0000, 16'h5678, 4'd6},  // R6 word read
    {2'b11, 1'b1, 1'b1, 16'h0000, 16'h1234, 4'd6},
    {2'b01, 1'b0, 1'b0, 16'h0013, 16'h0000, 4'd5},  // R5 low bits dropped
    {2'b01, 1'b1, 1'b0, 16'h0000, 16'h0010, 4'd5},
    {2'b10, 1'b1, 1'b0, 16'h0000, 16'h5004, 4'd9},  // R9 autoinc reads
    {2'b10, 1'b1, 1'b1, 16'h0000, 16'hA004, 4'd9},
    {2'b10, 1'b1, 1'b0, 16'h0000, 16'h5005, 4'd9},
    {2'b10, 1'b1, 1'b1, 16'h0000, 16'hA005, 4'd9},
    {2'b01, 1'b1, 1'b0, 16'h0000, 16'h0018, 4'd9}   // R1 pointer now word 6
  };

  initial begin
    logic [15:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 wait after reset", 32'(hWait), 32'd0);
    chk("R12 hIntN after reset", 32'(hIntN), 32'd1);
    chk("R12 coreIntReq after reset", 32'(coreIntReq), 32'd0);
    rd(2'b00, 1'b0, d);
    chk("R12 control after reset", 32'(d), 32'h0008);

    c0 = reqCount;
    for (int i = 0; i < 19; i++) begin
      logic [39:0] v;
      v = TBL[i];
      hostOp(v[39:38], v[37], v[36], 2'b00, v[35:20], d);
      if (v[37]) chk($sformatf("R%0d row %0d", v[3:0], i), 32'(d), 32'(v[19:4]));
    end
    chk("R7 memory word after write", mem[2], 32'h12345678);
    chk("R9 request count over table", reqCount - c0, 32'd5);

    // R3 high-half-first order
    wr(2'b00, 1'b0, 16'h0000); wr(2'b00, 1'b1, 16'h0000);
    wr(2'b01, 1'b0, 16'h0000); wr(2'b01, 1'b1, 16'h0004);
    wr(2'b11, 1'b0, 16'hAABB); wr(2'b11, 1'b1, 16'hCCDD);
    chk("R3 big order write", mem[1], 32'hAABBCCDD);
    c0 = reqCount;
    rd(2'b11, 1'b0, d); chk("R3 first half is high", 32'(d), 32'hAABB);
    rd(2'b11, 1'b1, d); chk("R3 second half is low", 32'(d), 32'hCCDD);
    chk("R6 one request per read pair", reqCount - c0, 32'd1);

    // R8 byte lanes: only bits 23:16 enabled
    hostOp(2'b11, 1'b0, 1'b0, 2'b10, 16'h0011, d);
    hostOp(2'b11, 1'b0, 1'b1, 2'b11, 16'hFFFF, d);
    chk("R8 byte lane write", mem[1], 32'hAA11CCDD);

    // R9 autoincrement after write
    wr(2'b10, 1'b0, 16'h1111); wr(2'b10, 1'b1, 16'h2222);
    chk("R9 autoinc write data", mem[1], 32'h11112222);
    rd(2'b01, 1'b1, d); chk("R9 pointer after write", 32'(d), 32'h0008);

    // R10 fetch bit
    wr(2'b01, 1'b0, 16'h0000); wr(2'b01, 1'b1, 16'h000C);
    c0 = reqCount;
    wr(2'b00, 1'b0, 16'h0010); wr(2'b00, 1'b1, 16'h0010);
    chk("R10 fetch launched one read", reqCount - c0, 32'd1);
    rd(2'b00, 1'b0, d); chk("R10 fetch bit reads 0", 32'(d), 32'h0008);
    rd(2'b10, 1'b0, d); chk("R10 fetched word used", 32'(d), 32'hA003);
    chk("R10 no extra request", reqCount - c0, 32'd1);
    rd(2'b10, 1'b1, d); chk("R10 second half", 32'(d), 32'h5003);

    // R4 interrupt bits
    wr(2'b00, 1'b0, 16'h0004); wr(2'b00, 1'b1, 16'h0004);
    chk("R4 hIntN low", 32'(hIntN), 32'd0);
    rd(2'b00, 1'b1, d); chk("R4 control image", 32'(d), 32'h000C);
    wr(2'b00, 1'b1, 16'h0002);
    chk("R4 hIntN high again", 32'(hIntN), 32'd1);
    chk("R4 coreIntReq set", 32'(coreIntReq), 32'd1);
    wr(2'b00, 1'b0, 16'h0000);
    chk("R4 coreIntReq cleared", 32'(coreIntReq), 32'd0);

    // R2 strobe qualification (pointer is word 4 after prefetch)
    rawOp(2'b01, 16'hFFFC, 1'b0, 1'b0, 1'b0);
    rawOp(2'b01, 16'hFFFC, 1'b0, 1'b1, 1'b1);
    rd(2'b01, 1'b1, d); chk("R2 invalid strobes ignored", 32'(d), 32'h0010);
    rawOp(2'b01, 16'h0020, 1'b1, 1'b0, 1'b0);
    rd(2'b01, 1'b1, d); chk("R2 second strobe works", 32'(d), 32'h0020);

    // R11 address strobe latch, fields scrambled after the latch
    c0 = reqCount;
    @(negedge clk);
    hSel = 2'b01; hRdWr = 1'b0; hHalf = 1'b1; tbOut = 16'h0030; tbDrv = 1'b1; hAsN = 1'b0;
    @(negedge clk);
    hSel = 2'b11; hRdWr = 1'b1; hHalf = 1'b0; hCsN = 1'b0;
    @(negedge clk);
    hDs1N = 1'b0;
    repeat (3) @(negedge clk);
    hDs1N = 1'b1;
    @(negedge clk);
    hCsN = 1'b1; tbDrv = 1'b0; hAsN = 1'b1;
    @(negedge clk);
    rd(2'b01, 1'b1, d); chk("R11 latched fields used", 32'(d), 32'h0030);
    chk("R11 no memory access", reqCount - c0, 32'd0);

    // R12 strobe during wait is dropped
    wr(2'b11, 1'b0, 16'h0000);
    @(negedge clk);
    hSel = 2'b11; hRdWr = 1'b0; hHalf = 1'b1; tbOut = 16'h0000; tbDrv = 1'b1; hCsN = 1'b0; hDs1N = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 wait raised by write", 32'(hWait), 32'd1);
    hDs1N = 1'b1; hCsN = 1'b1;
    @(negedge clk);
    hSel = 2'b01; tbOut = 16'h0040; hCsN = 1'b0; hDs1N = 1'b0;
    repeat (2) @(negedge clk);
    hDs1N = 1'b1; hCsN = 1'b1; tbDrv = 1'b0;
    while (hWait) @(negedge clk);
    rd(2'b01, 1'b1, d); chk("R12 strobe while waiting ignored", 32'(d), 32'h0030);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule